// File: doc/BRIEF.md
# Keyed Pointer Hash Engine

This block turns two 64-bit operands and a 64-bit secret into a 64-bit authentication digest. The operands are first byte-interleaved into two 64-bit words. Each word is split into two 32-bit halves, and each half is enciphered by a 16-bit-word Feistel cipher with 32 rounds. The four cipher lanes share one expanded key schedule, but each lane reads the round keys of every group of four in its own rotated order. The two lane-pair results are then XOR-folded into the digest. A caller uses the digest in one of two ways. In store mode it is written out to memory. In check mode it is compared against a value read back earlier, and a mismatch raises the trap output.

A request is accepted with a single-cycle start pulse while the engine is idle. The engine first expands the key, one recurrence step per clock. It then runs one round per clock in all four lanes together. At the end it presents the digest and the trap verdict with a one-cycle done pulse. Operands, key, mode and the compare value are all taken at the start edge. The results hold until the next finished request replaces them.

Top module: `pkh_engine`

## Requirements
- R1: After reset, busy, done and trap are 0 and digest is all zeros.
- R2: A start accepted while idle raises busy from the next cycle. Exactly 60 clock edges after the start edge (28 key steps plus 32 rounds), done is 1 for one cycle and busy is 0 from that cycle on.
- R3: The digest has a fixed derivation. The key splits into 16-bit words, with word 0 being key[63:48] and word 3 being key[15:0]. These words expand to 32 round keys by the stated recurrence, using constant 0xFFFC and z = bit (63-i) of 0xFA2561CDF44AC398. Lane L uses key 4g+((j+L) mod 4) in round 4g+j. A lane enciphers a block whose left half is bits 15:0 and whose right half is bits 31:16, and it returns {right, left}. The digest is {lane0(H[63:32]), lane1(H[31:0])} XOR {lane2(W[63:32]), lane3(W[31:0])}. H holds b bytes 0..3 at bits 63:56, 47:40, 31:24, 15:8 and a bytes 4..7 at bits 7:0, 23:16, 39:32, 55:48. W holds b bytes 4..7 and a bytes 0..3 at the same positions.
- R4: When mode_check was 1 at the start edge, trap equals 1 at done exactly when stored differs from the digest. Trap never rises outside a done cycle.
- R5: A start while busy is ignored. No extra done pulse follows, and the result is that of the first request, even if operands, key, mode and stored change during the run.
- R6: Digest and trap stay unchanged in every cycle in which done is 0. This holds across input changes while idle.
- R7: When mode_check was 0 at the start edge, trap is 0 at done whatever stored holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, taken only while idle |
| mode_check | input | 1 | 1: compare against stored, 0: produce digest for storing |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| key | input | 64 | Secret key |
| stored | input | 64 | Previously stored digest for check mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| digest | output | 64 | Computed digest, valid from done |
| trap | output | 1 | Check-mode mismatch verdict, valid from done |

## Verification
The only latency in this block is done, which is due 60 edges after the start edge. Busy is due one edge after start and falls on that same 60th edge. The bench drives every input on the falling edge and counts falling edges from the start edge until done appears, so the count must equal 60. It samples digest and trap in that same half cycle. On the following falling edge it confirms that done has dropped and that both results still hold. A checker counts clocks since the accepted start and requires done on the exact count, which also catches a restart caused by a start while busy.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  localparam int WORD_W     = 16;
  localparam int BLK_W      = 2 * WORD_W;
  localparam int NUM_LANES  = 4;
  localparam int KEY_WORDS  = 4;
  localparam int NUM_ROUNDS = 32;
  localparam int KEY_STEPS  = NUM_ROUNDS - KEY_WORDS;
  localparam int CNT_W      = $clog2(NUM_ROUNDS);
  localparam int DATA_W     = 64;
  localparam logic [63:0]       Z_SEQ     = 64'hFA2561CDF44AC398;
  localparam logic [WORD_W-1:0] KEY_CONST = 16'hFFFC;

  typedef enum logic [1:0] {ST_IDLE, ST_KEYX, ST_ROUND} phase_e;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v, input int unsigned n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction
endpackage

// File: rtl/pkh_keysched.sv
module pkh_keysched
  import pkh_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [DATA_W-1:0]                    key,
  input  logic                                 step_en,
  input  logic [CNT_W-1:0]                     step_idx,
  input  logic [NUM_LANES-1:0][CNT_W-1:0]      rd_idx,
  output logic [NUM_LANES-1:0][WORD_W-1:0]     rd_key
);
  localparam int ZS_W = $clog2(64);

  logic [WORD_W-1:0] kmem_q [NUM_ROUNDS];
  logic [WORD_W-1:0] kmem_d [NUM_ROUNDS];
  logic [CNT_W-1:0]  i0, i1, i3, i4;
  logic [ZS_W-1:0]   zsel;
  logic [WORD_W-1:0] tmp;
  logic              zbit;

  always_comb begin
    i0   = step_idx;
    i1   = i0 + CNT_W'(1);
    i3   = i0 + CNT_W'(3);
    i4   = i0 + CNT_W'(4);
    zsel = ZS_W'(63) - ZS_W'(step_idx);
    zbit = Z_SEQ[zsel];
    tmp  = rotr(kmem_q[i3], 3) ^ kmem_q[i1];
    kmem_d = kmem_q;
    if (load) begin
      for (int w = 0; w < KEY_WORDS; w++)
        kmem_d[w] = key[(KEY_WORDS-1-w)*WORD_W +: WORD_W];
    end else if (step_en) begin
      kmem_d[i4] = KEY_CONST ^ {{(WORD_W-1){1'b0}}, zbit} ^ kmem_q[i0] ^ tmp ^ rotr(tmp, 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_ROUNDS; w++) kmem_q[w] <= '0;
    end else if (load || step_en) begin
      kmem_q <= kmem_d;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_rd
    assign rd_key[l] = kmem_q[rd_idx[l]];
  end
endmodule

// File: rtl/pkh_lane.sv
module pkh_lane
  import pkh_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic              rnd_en,
  input  logic [CNT_W-1:0]  rnd_idx,
  output logic [CNT_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] rkey,
  output logic [BLK_W-1:0]  blk_nxt
);
  logic [WORD_W-1:0] left_q, right_q, left_d, right_d, fval;

  assign key_idx = {rnd_idx[CNT_W-1:2], rnd_idx[1:0] + 2'(LANE)};

  always_comb begin
    fval    = (rotl(left_q, 1) & rotl(left_q, 8)) ^ rotl(left_q, 2);
    left_d  = left_q;
    right_d = right_q;
    if (load) begin
      left_d  = blk_in[WORD_W-1:0];
      right_d = blk_in[BLK_W-1:WORD_W];
    end else if (rnd_en) begin
      left_d  = right_q ^ fval ^ rkey;
      right_d = left_q;
    end
  end

  assign blk_nxt = {right_d, left_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (load || rnd_en) begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end
endmodule

// File: rtl/pkh_engine.sv
module pkh_engine
  import pkh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_check,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] key,
  input  logic [DATA_W-1:0] stored,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] digest,
  output logic              trap
);
  logic [1:0]        rsync_q;
  logic              rst_n_s;
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              mode_q, mode_d, done_q, done_d, trap_q, trap_d;
  logic [DATA_W-1:0] stored_q, stored_d, dig_q, dig_d;
  logic [DATA_W-1:0] word_h, word_w, fold_nxt;
  logic [2*DATA_W-1:0] word_cat;
  logic              accept, step_en, rnd_en;
  logic [NUM_LANES-1:0][CNT_W-1:0]  lane_kidx;
  logic [NUM_LANES-1:0][WORD_W-1:0] lane_rkey;
  logic [NUM_LANES-1:0][BLK_W-1:0]  lane_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  always_comb begin
    word_h = '0;
    word_w = '0;
    for (int i = 0; i < 4; i++) begin
      word_h[56-16*i +: 8] = opnd_b[8*i +: 8];
      word_h[16*i +: 8]    = opnd_a[32+8*i +: 8];
      word_w[56-16*i +: 8] = opnd_b[32+8*i +: 8];
      word_w[16*i +: 8]    = opnd_a[8*i +: 8];
    end
  end
  assign word_cat = {word_h, word_w};

  assign accept  = start && (phase_q == ST_IDLE);
  assign step_en = (phase_q == ST_KEYX);
  assign rnd_en  = (phase_q == ST_ROUND);

  pkh_keysched u_keys (
    .clk(clk), .rst_n(rst_n_s), .load(accept), .key(key),
    .step_en(step_en), .step_idx(cnt_q), .rd_idx(lane_kidx), .rd_key(lane_rkey)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    pkh_lane #(.LANE(l)) u_lane (
      .clk(clk), .rst_n(rst_n_s), .load(accept),
      .blk_in(word_cat[2*DATA_W-1-BLK_W*l -: BLK_W]),
      .rnd_en(rnd_en), .rnd_idx(cnt_q), .key_idx(lane_kidx[l]),
      .rkey(lane_rkey[l]), .blk_nxt(lane_nxt[l])
    );
  end

  assign fold_nxt = {lane_nxt[0], lane_nxt[1]} ^ {lane_nxt[2], lane_nxt[3]};

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    stored_d = stored_q;
    dig_d    = dig_q;
    trap_d   = trap_q;
    done_d   = 1'b0;
    case (phase_q)
      ST_IDLE: begin
        if (start) begin
          phase_d  = ST_KEYX;
          cnt_d    = '0;
          mode_d   = mode_check;
          stored_d = stored;
        end
      end
      ST_KEYX: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(KEY_STEPS-1)) begin
          phase_d = ST_ROUND;
          cnt_d   = '0;
        end
      end
      ST_ROUND: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(NUM_ROUNDS-1)) begin
          phase_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
          dig_d   = fold_nxt;
          trap_d  = mode_q && (fold_nxt != stored_q);
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q  <= ST_IDLE;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      stored_q <= '0;
      dig_q    <= '0;
      trap_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      stored_q <= stored_d;
      dig_q    <= dig_d;
      trap_q   <= trap_d;
      done_q   <= done_d;
    end
  end

  assign busy   = (phase_q != ST_IDLE);
  assign done   = done_q;
  assign digest = dig_q;
  assign trap   = trap_q;
endmodule

// File: rtl/pkh_engine_chk.sv
module pkh_engine_chk
  import pkh_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              trap,
  input logic [DATA_W-1:0] digest,
  input logic              mode_q
);
  localparam int LAT = KEY_STEPS + NUM_ROUNDS;
  logic [7:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (start && !busy) cyc_q <= 8'd1;
    else if (busy)           cyc_q <= cyc_q + 8'd1;
    else                     cyc_q <= '0;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cyc_q == 8'(LAT + 1))); // R5
  AST_TRAP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(trap) |-> done); // R4
  AST_STORE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (done && !mode_q) |-> !trap); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(digest) && $stable(trap))); // R6
endmodule

bind pkh_engine pkh_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .start(start), .busy(busy), .done(done),
  .trap(trap), .digest(digest), .mode_q(mode_q)
);

// File: tb/test_pkh_engine.sv
`timescale 1ns/1ps
module test_pkh_engine;
  localparam logic [63:0] ZC = 64'hFA2561CDF44AC398;
  localparam int EXP_LAT = 60;

  logic clk, rst_n, start, mode_check;
  logic [63:0] opnd_a, opnd_b, key, stored;
  logic busy, done, trap;
  logic [63:0] digest;
  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  pkh_engine i_pkh_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_check(mode_check),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .key(key), .stored(stored),
    .busy(busy), .done(done), .digest(digest), .trap(trap)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] m_rol(input logic [15:0] v, input int n);
    return (v << n) | (v >> (16 - n));
  endfunction
  function automatic logic [15:0] m_ror(input logic [15:0] v, input int n);
    return (v >> n) | (v << (16 - n));
  endfunction

  function automatic logic [31:0] m_cipher(input logic [31:0] x, input logic [63:0] kk, input int lane);
    logic [15:0] ks [32];
    logic [15:0] lf, rt, t, f;
    for (int w = 0; w < 4; w++) ks[w] = kk[63-16*w -: 16];
    for (int i = 0; i < 28; i++) begin
      t = m_ror(ks[i+3], 3) ^ ks[i+1];
      ks[i+4] = 16'hFFFC ^ {15'b0, ZC[63-i]} ^ ks[i] ^ t ^ m_ror(t, 1);
    end
    lf = x[15:0];
    rt = x[31:16];
    for (int i = 0; i < 32; i++) begin
      f  = (m_rol(lf, 1) & m_rol(lf, 8)) ^ m_rol(lf, 2);
      t  = rt ^ f ^ ks[(i/4)*4 + (((i%4) + lane) % 4)];
      rt = lf;
      lf = t;
    end
    return {rt, lf};
  endfunction

  function automatic logic [63:0] m_digest(input logic [63:0] a, input logic [63:0] b, input logic [63:0] kk);
    logic [63:0] h, w;
    h = '0;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      h = h | ({56'b0, b[8*i +: 8]} << (56 - 16*i)) | ({56'b0, a[32+8*i +: 8]} << (16*i));
      w = w | ({56'b0, b[32+8*i +: 8]} << (56 - 16*i)) | ({56'b0, a[8*i +: 8]} << (16*i));
    end
    return {m_cipher(h[63:32], kk, 0), m_cipher(h[31:0], kk, 1)} ^
           {m_cipher(w[63:32], kk, 2), m_cipher(w[31:0], kk, 3)};
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 7);
    v = v ^ (v << 17);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [63:0] kk,
                     input bit md, input logic [63:0] st, input bit inject);
    logic [63:0] exp_d, held_d;
    bit exp_t, held_t;
    int n;
    exp_d = m_digest(a, b, kk);
    exp_t = md && (st != exp_d);
    @(negedge clk);
    opnd_a = a; opnd_b = b; key = kk; mode_check = md; stored = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", {63'b0, busy}, 64'd1);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (inject && n == 10) begin
        opnd_a = ~a; opnd_b = a; key = ~kk; mode_check = ~md; stored = ~st; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(n == EXP_LAT, inject ? "R5" : "R2", "done latency", 64'(n), 64'(EXP_LAT));
    check(busy == 1'b0, "R2", "busy at done", {63'b0, busy}, 64'd0);
    check(digest == exp_d, inject ? "R5" : "R3", "digest", digest, exp_d);
    check(trap == exp_t, md ? "R4" : "R7", "trap", {63'b0, trap}, {63'b0, exp_t});
    held_d = digest;
    held_t = trap;
    @(negedge clk);
    check(done == 1'b0, "R2", "done one cycle", {63'b0, done}, 64'd0);
    opnd_a = next_rand(a); key = next_rand(kk); stored = ~stored; mode_check = ~mode_check;
    @(negedge clk);
    check(digest == held_d && trap == held_t, "R6", "result hold", digest, held_d);
  endtask

  initial begin
    #1000000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, kk, d;
    rst_n = 1'b0; start = 1'b0; mode_check = 1'b0;
    opnd_a = '0; opnd_b = '0; key = '0; stored = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && trap == 1'b0, "R1", "reset flags",
          {61'b0, busy, done, trap}, 64'd0);
    check(digest == 64'd0, "R1", "reset digest", digest, 64'd0);

    run(64'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0);
    run('1, '1, '1, 1'b0, '1, 1'b0);
    run(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978, 1'b0, '0, 1'b0);
    d = m_digest(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978);
    run(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978, 1'b1, d, 1'b0);
    run(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978, 1'b1, d ^ 64'h1, 1'b0);

    for (int v = 0; v < 40; v++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      seed = next_rand(seed); kk = seed;
      if (v < 8) kk = 64'h1 << (v * 8);
      d = m_digest(a, b, kk);
      run(a, b, kk, 1'b0, ~d, 1'b0);
      run(a, b, kk, 1'b1, d, 1'b0);
      run(a, b, kk, 1'b1, d ^ (64'h1 << (v + 20)), 1'b0);
    end

    seed = next_rand(seed);
    a = seed;
    d = m_digest(a, ~a, 64'hC001D00DCAFEF00D);
    run(a, ~a, 64'hC001D00DCAFEF00D, 1'b1, d, 1'b1);
    begin
      int extra;
      extra = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R5", "no second done", 64'(extra), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule